// File: doc/BRIEF.md
# Hypervisor Debug Trap Controller

This block holds the hypervisor's debug control word and decides, request by request, whether a guest access must be handed up to the hypervisor. The control word sets which debug and performance-monitor operations trap. It also holds a threshold that splits the event counters into a guest part and a hypervisor part. Software reads and writes the word through a simple strobe interface. That interface is honoured only from hypervisor mode, or from monitor mode with the non-secure flag set.

Each request carries a class code, the requester's security state, its privilege level, a user-access enable and a counter index. One cycle later the block drives two registered outputs. One says whether the request traps. The other says whether the addressed counter lies in a partition the requester may use. Writes are cleaned up before they are stored. The four debug trap bits always form one of the six legal combinations, and the threshold never exceeds the number of implemented counters.

Top module: `hyp_dbg_trap_ctl`

## Requirements
- R1: After reset the control word reads 0x0000_0004: every trap bit and the counter enable bit are 0, and the threshold equals the counter count (default 4).
- R2: A write takes effect and a read returns data only while `cur_hyp` or `mon_ns` is 1. Otherwise the write leaves the word unchanged and `cfg_rdata` is 0.
- R3: Bits 31:12 always read as 0 and ignore written values.
- R4: Bits 11:8 hold the trap group {ROM, OS, DBG, EXC}. When bit 8 is written as 1, bits 11:9 are stored as 1. When bit 9 is written as 1, bits 11:10 are stored as 1. Bits 11 and 10 are otherwise stored as written.
- R5: Bits 4:0 hold the threshold. A written threshold above the counter count is stored as the counter count.
- R6: The debug classes are encoded as ROM=0, OS=1, DBG=2 and EXC=3. For a guest request (non-secure, level 0 or 1), these classes trap when bit 11, bit 10, bit 9 and bit 8 respectively is set.
- R7: The monitor classes are encoded as PMU=4, PMCR=5 and CNT=6. A guest PMU request or CNT request traps when bit 6 is set. A guest PMCR request traps when bit 5 or bit 6 is set.
- R8: A secure request, or a request at level 2 or above, never traps.
- R9: For a non-secure request at level 0 or 1, `cnt_ok_o` is 1 for a CNT request only when the index is below the threshold and either the level is 1 or `req_user_en` is 1.
- R10: For a non-secure request at level 2 or above, `cnt_ok_o` is 1 for a CNT request only when the index is below the threshold, or when the index is below the counter count and bit 7 is set.
- R11: For a secure request, `cnt_ok_o` is 1 for a CNT request exactly when the index is below the counter count.
- R12: `trap_o` and `cnt_ok_o` are registered. They reflect the request presented in the previous cycle, and they are 0 when `req_valid` was 0 in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cur_hyp | input | 1 | Requester of the control access is in hypervisor mode |
| mon_ns | input | 1 | Monitor mode is active with the non-secure flag set |
| cfg_wr_en | input | 1 | Control word write strobe |
| cfg_rd_en | input | 1 | Control word read strobe |
| cfg_wdata | input | 32 | Control word write data |
| cfg_rdata | output | 32 | Control word read data (0 when not permitted) |
| req_valid | input | 1 | A classified request is present |
| req_class | input | 3 | Request class code |
| req_ns | input | 1 | Request comes from non-secure state |
| req_pl | input | 2 | Privilege level of the request |
| req_user_en | input | 1 | Level-0 counter access is enabled |
| req_idx | input | 5 | Counter index for CNT requests |
| trap_o | output | 1 | Request traps to the hypervisor (registered) |
| cnt_ok_o | output | 1 | Counter access permitted (registered) |

## Verification
The trap decision is exercised with one trap bit set at a time. This shows that each class reads its own bit and not a neighbour's. The same requests are then repeated from secure state and from level 2, which separates the privilege and security gate from the bit decode. Counter permission is probed at indices just below and at the threshold, and at and above the counter count. This is done from each level with the hypervisor enable off and on, so the two partition boundaries can be told apart. Writes with illegal trap groups and oversized thresholds show the normalisation and the clamp.

// File: rtl/hyp_dbg_trap_ctl.sv
module hyp_dbg_trap_ctl #(
  parameter int NUM_CNT = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cur_hyp,
  input  logic        mon_ns,
  input  logic        cfg_wr_en,
  input  logic        cfg_rd_en,
  input  logic [31:0] cfg_wdata,
  output logic [31:0] cfg_rdata,
  input  logic        req_valid,
  input  logic [2:0]  req_class,
  input  logic        req_ns,
  input  logic [1:0]  req_pl,
  input  logic        req_user_en,
  input  logic [4:0]  req_idx,
  output logic        trap_o,
  output logic        cnt_ok_o
);
  localparam int          IW   = 5;
  localparam logic [IW-1:0] NCNT = IW'(NUM_CNT);
  localparam logic [2:0]  C_ROM = 3'd0, C_OS = 3'd1, C_DBG = 3'd2, C_EXC = 3'd3,
                          C_PMU = 3'd4, C_PMCR = 3'd5, C_CNT = 3'd6;

  logic [11:0]   ctl_q;
  logic [11:0]   ctl_d;
  logic [3:0]    trp_w;
  logic [IW-1:0] thr_w;
  logic          acc_ok, guest, idx_lo, idx_in, trap_c, cnt_c;

  assign acc_ok = cur_hyp | mon_ns;

  assign trp_w = {cfg_wdata[11] | cfg_wdata[9] | cfg_wdata[8],
                  cfg_wdata[10] | cfg_wdata[9] | cfg_wdata[8],
                  cfg_wdata[9]  | cfg_wdata[8],
                  cfg_wdata[8]};
  assign thr_w = (cfg_wdata[4:0] > NCNT) ? NCNT : cfg_wdata[4:0];
  assign ctl_d = {trp_w, cfg_wdata[7:5], thr_w};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   ctl_q <= {7'b0, NCNT};
    else if (cfg_wr_en && acc_ok) ctl_q <= ctl_d;
  end

  assign cfg_rdata = (cfg_rd_en && acc_ok) ? {20'b0, ctl_q} : 32'b0;

  assign guest  = req_ns && (req_pl < 2'd2);
  assign idx_lo = req_idx < ctl_q[4:0];
  assign idx_in = req_idx < NCNT;

  always_comb begin
    unique case (req_class)
      C_ROM:   trap_c = ctl_q[11];
      C_OS:    trap_c = ctl_q[10];
      C_DBG:   trap_c = ctl_q[9];
      C_EXC:   trap_c = ctl_q[8];
      C_PMU:   trap_c = ctl_q[6];
      C_PMCR:  trap_c = ctl_q[6] | ctl_q[5];
      C_CNT:   trap_c = ctl_q[6];
      default: trap_c = 1'b0;
    endcase
    trap_c = trap_c & guest;
  end

  always_comb begin
    if (!req_ns)            cnt_c = idx_in;
    else if (req_pl >= 2'd2) cnt_c = idx_in && (idx_lo || ctl_q[7]);
    else                    cnt_c = idx_lo && (req_pl == 2'd1 || req_user_en);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trap_o   <= 1'b0;
      cnt_ok_o <= 1'b0;
    end else begin
      trap_o   <= req_valid && trap_c;
      cnt_ok_o <= req_valid && (req_class == C_CNT) && cnt_c;
    end
  end
endmodule

module hyp_dbg_trap_ctl_chk #(
  parameter int NUM_CNT = 4
) (
  input logic        clk,
  input logic        rst_n,
  input logic        cur_hyp,
  input logic        mon_ns,
  input logic        cfg_wr_en,
  input logic [31:0] cfg_rdata,
  input logic        req_valid,
  input logic [2:0]  req_class,
  input logic        req_ns,
  input logic [1:0]  req_pl,
  input logic [4:0]  req_idx,
  input logic        trap_o,
  input logic        cnt_ok_o,
  input logic [11:0] ctl_q
);
  localparam logic [4:0] NCNT = 5'(NUM_CNT);

  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n) cfg_rdata[31:12] == 20'b0); // R3
  AST_GATED_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_wr_en || !(cur_hyp || mon_ns)) |=> $stable(ctl_q)); // R2
  AST_LEGAL_TRAPS: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl_q[8] || ctl_q[11:9] == 3'b111) && (!ctl_q[9] || ctl_q[11:10] == 2'b11)); // R4
  AST_THR_BOUND: assert property (@(posedge clk) disable iff (!rst_n) ctl_q[4:0] <= NCNT); // R5
  AST_NO_TRAP_PRIV: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && (!req_ns || req_pl >= 2'd2)) |=> !trap_o); // R8
  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_class == 3'd6 && req_idx >= NCNT) |=> !cnt_ok_o); // R10
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (!trap_o && !cnt_ok_o)); // R12
endmodule

bind hyp_dbg_trap_ctl hyp_dbg_trap_ctl_chk #(.NUM_CNT(NUM_CNT)) chk_i (
  .clk(clk), .rst_n(rst_n), .cur_hyp(cur_hyp), .mon_ns(mon_ns), .cfg_wr_en(cfg_wr_en),
  .cfg_rdata(cfg_rdata), .req_valid(req_valid), .req_class(req_class), .req_ns(req_ns),
  .req_pl(req_pl), .req_idx(req_idx), .trap_o(trap_o), .cnt_ok_o(cnt_ok_o), .ctl_q(ctl_q)
);

// File: tb/hyp_dbg_trap_ctl_tb.sv
module hyp_dbg_trap_ctl_tb_top;
  logic        clk = 0, rst_n = 0;
  logic        cur_hyp = 0, mon_ns = 0, cfg_wr_en = 0, cfg_rd_en = 0;
  logic [31:0] cfg_wdata = 0, cfg_rdata;
  logic        req_valid = 0, req_ns = 0, req_user_en = 0;
  logic [2:0]  req_class = 0;
  logic [1:0]  req_pl = 0;
  logic [4:0]  req_idx = 0;
  logic        trap_o, cnt_ok_o;
  int          n_chk = 0, n_err = 0;
  bit          done = 0;

  hyp_dbg_trap_ctl dut_i (.*);

  always #2 clk = ~clk;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic hyp, input logic mns, input logic [31:0] d);
    @(negedge clk);
    cur_hyp = hyp; mon_ns = mns; cfg_wr_en = 1; cfg_wdata = d;
    @(negedge clk);
    cfg_wr_en = 0; cur_hyp = 0; mon_ns = 0;
  endtask

  task automatic rd(input logic hyp, input logic mns, output logic [31:0] d);
    @(negedge clk);
    cur_hyp = hyp; mon_ns = mns; cfg_rd_en = 1;
    #1 d = cfg_rdata;
    cfg_rd_en = 0; cur_hyp = 0; mon_ns = 0;
  endtask

  task automatic req(input logic [2:0] c, input logic ns, input logic [1:0] pl,
                     input logic ue, input logic [4:0] idx, output logic t, output logic ok);
    @(negedge clk);
    req_valid = 1; req_class = c; req_ns = ns; req_pl = pl; req_user_en = ue; req_idx = idx;
    @(posedge clk); #1;
    t = trap_o; ok = cnt_ok_o;
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic t_reset();
    logic [31:0] d; logic t, ok;
    rd(1, 0, d);                 check("R1 reset word", d, 32'h4);
    req(3'd0, 1, 1, 0, 0, t, ok); check("R1 no trap after reset", t, 0);
    req(3'd6, 1, 2, 0, 4, t, ok); check("R1 hyp counter disabled", ok, 0);
  endtask

  task automatic t_access();
    logic [31:0] d;
    wr(0, 0, 32'hFFFF_FFFF); rd(1, 0, d); check("R2 gated write ignored", d, 32'h4);
    rd(0, 0, d);                          check("R2 gated read zero", d, 0);
    wr(0, 1, 32'h0000_0102); rd(0, 1, d); check("R2 monitor-ns write", d, 32'hF02);
  endtask

  task automatic t_rsvd();
    logic [31:0] d;
    wr(1, 0, 32'hFFFF_F0A3); rd(1, 0, d); check("R3 reserved bits zero", d, 32'h0A3);
  endtask

  task automatic t_norm();
    logic [31:0] d;
    wr(1, 0, 32'h204); rd(1, 0, d); check("R4 bit9 forces 11:10", d, 32'hE04);
    wr(1, 0, 32'h804); rd(1, 0, d); check("R4 rom only", d, 32'h804);
    wr(1, 0, 32'h404); rd(1, 0, d); check("R4 os only", d, 32'h404);
    wr(1, 0, 32'hB04); rd(1, 0, d); check("R4 bit8 forces all", d, 32'hF04);
    wr(1, 0, 32'hA04); rd(1, 0, d); check("R4 1010 to 1110", d, 32'hE04);
  endtask

  task automatic t_clamp();
    logic [31:0] d;
    wr(1, 0, 32'h1F); rd(1, 0, d); check("R5 clamp 31", d, 32'h4);
    wr(1, 0, 32'h05); rd(1, 0, d); check("R5 clamp 5", d, 32'h4);
    wr(1, 0, 32'h03); rd(1, 0, d); check("R5 keep 3", d, 32'h3);
  endtask

  task automatic t_dbg();
    logic t, ok;
    wr(1, 0, 32'h404);
    req(3'd0, 1, 1, 0, 0, t, ok); check("R6 rom clear", t, 0);
    req(3'd1, 1, 1, 0, 0, t, ok); check("R6 os set", t, 1);
    req(3'd2, 1, 1, 0, 0, t, ok); check("R6 dbg clear", t, 0);
    req(3'd3, 1, 0, 0, 0, t, ok); check("R6 exc clear", t, 0);
    wr(1, 0, 32'h804);
    req(3'd0, 1, 0, 0, 0, t, ok); check("R6 rom set", t, 1);
    req(3'd1, 1, 1, 0, 0, t, ok); check("R6 os clear", t, 0);
    wr(1, 0, 32'hE04);
    req(3'd2, 1, 1, 0, 0, t, ok); check("R6 dbg set", t, 1);
    req(3'd3, 1, 1, 0, 0, t, ok); check("R6 exc still clear", t, 0);
    wr(1, 0, 32'hF44);
    req(3'd3, 1, 0, 0, 0, t, ok); check("R6 exc set", t, 1);
    req(3'd3, 0, 1, 0, 0, t, ok); check("R8 secure exc", t, 0);
    req(3'd0, 1, 2, 0, 0, t, ok); check("R8 level2 rom", t, 0);
    req(3'd4, 0, 0, 0, 0, t, ok); check("R8 secure pmu", t, 0);
  endtask

  task automatic t_pm();
    logic t, ok;
    wr(1, 0, 32'h024);
    req(3'd5, 1, 1, 0, 0, t, ok); check("R7 pmcr by bit5", t, 1);
    req(3'd4, 1, 1, 0, 0, t, ok); check("R7 pmu clear", t, 0);
    req(3'd6, 1, 1, 0, 0, t, ok); check("R7 cnt clear", t, 0);
    wr(1, 0, 32'h044);
    req(3'd4, 1, 1, 0, 0, t, ok); check("R7 pmu set", t, 1);
    req(3'd5, 1, 0, 0, 0, t, ok); check("R7 pmcr by bit6", t, 1);
    req(3'd6, 1, 1, 0, 1, t, ok); check("R7 cnt set", t, 1);
  endtask

  task automatic t_cnt();
    logic t, ok;
    wr(1, 0, 32'h002);
    req(3'd6, 1, 1, 0, 1, t, ok); check("R9 below thr", ok, 1);
    req(3'd6, 1, 1, 0, 2, t, ok); check("R9 at thr", ok, 0);
    req(3'd6, 1, 0, 0, 1, t, ok); check("R9 user off", ok, 0);
    req(3'd6, 1, 0, 1, 1, t, ok); check("R9 user on", ok, 1);
    req(3'd6, 1, 2, 0, 2, t, ok); check("R10 hyp part disabled", ok, 0);
    req(3'd4, 1, 2, 0, 0, t, ok); check("R10 non-cnt class", ok, 0);
    wr(1, 0, 32'h082);
    req(3'd6, 1, 2, 0, 3, t, ok); check("R10 hyp part enabled", ok, 1);
    req(3'd6, 1, 2, 0, 4, t, ok); check("R10 beyond count", ok, 0);
    req(3'd6, 0, 1, 0, 3, t, ok); check("R11 secure in range", ok, 1);
    req(3'd6, 0, 1, 0, 4, t, ok); check("R11 secure out", ok, 0);
  endtask

  task automatic t_timing();
    wr(1, 0, 32'h044);
    @(negedge clk);
    req_valid = 1; req_class = 3'd6; req_ns = 1; req_pl = 1; req_idx = 0; req_user_en = 0;
    #1 check("R12 not yet registered", trap_o, 0);
    @(posedge clk); #1 check("R12 registered trap", trap_o, 1);
    check("R12 registered cnt", cnt_ok_o, 1);
    @(negedge clk); req_valid = 0;
    @(posedge clk); #1 check("R12 idle trap", trap_o, 0);
    check("R12 idle cnt", cnt_ok_o, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset(); t_access(); t_rsvd(); t_norm(); t_clamp(); t_dbg(); t_pm(); t_cnt(); t_timing();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    #400000;
    if (!done) begin
      done = 1;
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule